// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block creates the two doorbell flags that let the two sides of a shared dual-port byte memory signal each other. Each side owns one mailbox word at the top of the address space. The left side owns the next-to-last word and the right side owns the last word. When one side writes into the other side's mailbox, the owner's flag rises. The owner drops its flag by reading its own mailbox. The mailbox bytes stay in the RAM as ordinary storage and hold whatever message software puts there. This block only watches the port strobes and does not touch the data.

All port controls are active-high and sampled on the rising clock edge. Both flags are registered and change one edge after the qualifying access. Each side has a busy input from the contention arbiter. While a side's busy input is high, that side's accesses neither raise nor drop any flag. A parameter removes the mailbox logic, and both flags then stay low.

Top module: `mbox_irq_flags`

## Requirements
- R1: After reset, both `lt_irq` and `rt_irq` are 0.
- R2: A right-side cycle with `rt_en`=1, `rt_wr`=1 and `rt_addr` equal to 2^ADDR_W-2 (0x7FE by default) sets `lt_irq` to 1 at the next rising edge.
- R3: A left-side cycle with `lt_en`=1, `lt_oe`=1 and `lt_addr`=2^ADDR_W-2 clears `lt_irq` at the next rising edge, whatever the value of `lt_wr`.
- R4: A left-side cycle with `lt_en`=1, `lt_wr`=1 and `lt_addr`=2^ADDR_W-1 (0x7FF by default) sets `rt_irq` at the next rising edge.
- R5: A right-side cycle with `rt_en`=1, `rt_oe`=1 and `rt_addr`=2^ADDR_W-1 clears `rt_irq` at the next rising edge, whatever the value of `rt_wr`.
- R6: A set or clear attempt made by a side whose busy input is 1 leaves the affected flag unchanged.
- R7: If a set and a clear of the same flag happen in the same cycle, the flag becomes 1.
- R8: In all other cases the flags hold their values. This covers any other address, a missing enable, output enable or write strobe, and a side writing to its own mailbox.
- R9: With MBOX_EN=0, both flags stay 0 under any stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lt_en | input | 1 | Left chip enable |
| lt_oe | input | 1 | Left output enable |
| lt_wr | input | 1 | Left write strobe |
| lt_addr | input | ADDR_W | Left address |
| lt_busy | input | 1 | Left busy from the arbiter |
| rt_en | input | 1 | Right chip enable |
| rt_oe | input | 1 | Right output enable |
| rt_wr | input | 1 | Right write strobe |
| rt_addr | input | ADDR_W | Right address |
| rt_busy | input | 1 | Right busy from the arbiter |
| lt_irq | output | 1 | Flag for the left side |
| rt_irq | output | 1 | Flag for the right side |

## Verification
The bench checks several cases that a faulty design would get wrong:
- A clear made with the write strobe also high. A design that requires a pure read would leave the flag up.
- A set and a clear of the same flag in one cycle. A design with clear priority would lose the doorbell.
- Busy on the posting side and on the reading side. A design that gates with the wrong side's busy would change the flag anyway.
- A side writing its own mailbox, a neighbouring address, and an access without enable or without output enable. A loose address or strobe decode would raise or drop a flag on one of these.
- A second instance with the mailbox logic disabled. Its flags must stay low through all of the above.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   typedef enum logic {SIDE_LT = 1'b0, SIDE_RT = 1'b1} side_e;

   // Mailbox word owned by a side: the two topmost addresses, left below right.
   function automatic int unsigned mbox_word(input int unsigned aw, input side_e s);
      return (32'd1 << aw) - 32'd2 + ((s == SIDE_RT) ? 32'd1 : 32'd0);
   endfunction
endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec #(
   parameter int unsigned ADDR_W    = 11,
   parameter int unsigned OWN_WORD  = 2046,
   parameter int unsigned PEER_WORD = 2047
) (
   input  logic              en,
   input  logic              oe,
   input  logic              wr,
   input  logic              busy,
   input  logic [ADDR_W-1:0] addr,
   output logic              post,
   output logic              take
);
   localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(OWN_WORD);
   localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(PEER_WORD);

   initial begin
      if (OWN_WORD == PEER_WORD)
         $error("mbox_port_dec: own and peer mailbox must differ");
   end

   logic granted;
   assign granted = en & ~busy;
   assign post    = granted & wr & (addr == PEER_A);
   assign take    = granted & oe & (addr == OWN_A);
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> q); // R7
   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !q); // R3
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!set && !clr) |=> $stable(q)); // R8
endmodule

// File: rtl/mbox_irq_flags.sv
module mbox_irq_flags #(
   parameter int unsigned ADDR_W  = 11,
   parameter bit          MBOX_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lt_en,
   input  logic              lt_oe,
   input  logic              lt_wr,
   input  logic [ADDR_W-1:0] lt_addr,
   input  logic              lt_busy,
   input  logic              rt_en,
   input  logic              rt_oe,
   input  logic              rt_wr,
   input  logic [ADDR_W-1:0] rt_addr,
   input  logic              rt_busy,
   output logic              lt_irq,
   output logic              rt_irq
);
   import mbox_pkg::*;

   localparam int unsigned LT_WORD = mbox_word(ADDR_W, SIDE_LT);
   localparam int unsigned RT_WORD = mbox_word(ADDR_W, SIDE_RT);

   initial begin
      if (ADDR_W < 2 || ADDR_W > 30)
         $error("mbox_irq_flags: ADDR_W out of range");
   end

   generate
      if (MBOX_EN) begin : g_mbox
         logic lt_post, lt_take, rt_post, rt_take;

         mbox_port_dec #(.ADDR_W(ADDR_W), .OWN_WORD(LT_WORD), .PEER_WORD(RT_WORD)) i_lt_dec (
            .en(lt_en), .oe(lt_oe), .wr(lt_wr), .busy(lt_busy), .addr(lt_addr),
            .post(lt_post), .take(lt_take));

         mbox_port_dec #(.ADDR_W(ADDR_W), .OWN_WORD(RT_WORD), .PEER_WORD(LT_WORD)) i_rt_dec (
            .en(rt_en), .oe(rt_oe), .wr(rt_wr), .busy(rt_busy), .addr(rt_addr),
            .post(rt_post), .take(rt_take));

         // A side's flag is set by the peer's post and cleared by its own take.
         mbox_flag i_lt_flag (.clk(clk), .rst_n(rst_n), .set(rt_post), .clr(lt_take), .q(lt_irq));
         mbox_flag i_rt_flag (.clk(clk), .rst_n(rst_n), .set(lt_post), .clr(rt_take), .q(rt_irq));

         AST_BOTH_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
            (lt_busy && rt_busy) |=> ($stable(lt_irq) && $stable(rt_irq))); // R6
         AST_PEER_WRITE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
            (rt_en && rt_wr && !rt_busy && rt_addr == ADDR_W'(LT_WORD)) |=> lt_irq); // R2
         AST_LEFT_WRITE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
            (lt_en && lt_wr && !lt_busy && lt_addr == ADDR_W'(RT_WORD)) |=> rt_irq); // R4
      end else begin : g_off
         assign lt_irq = 1'b0;
         assign rt_irq = 1'b0;
         AST_FLAGS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (!lt_irq && !rt_irq)); // R9
      end
   endgenerate
endmodule

// File: tb/test_mbox_irq_flags.sv
module test_mbox_irq_flags;
   localparam int AW = 11;
   localparam logic [AW-1:0] LTM = 11'h7FE;
   localparam logic [AW-1:0] RTM = 11'h7FF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lt_en = 0, lt_oe = 0, lt_wr = 0, lt_busy = 0;
   logic rt_en = 0, rt_oe = 0, rt_wr = 0, rt_busy = 0;
   logic [AW-1:0] lt_addr = '0, rt_addr = '0;
   logic lt_irq, rt_irq, off_lt, off_rt;

   always #4 clk = ~clk;

   mbox_irq_flags #(.ADDR_W(AW), .MBOX_EN(1'b1)) i_mbox_irq_flags (
      .clk(clk), .rst_n(rst_n),
      .lt_en(lt_en), .lt_oe(lt_oe), .lt_wr(lt_wr), .lt_addr(lt_addr), .lt_busy(lt_busy),
      .rt_en(rt_en), .rt_oe(rt_oe), .rt_wr(rt_wr), .rt_addr(rt_addr), .rt_busy(rt_busy),
      .lt_irq(lt_irq), .rt_irq(rt_irq));

   mbox_irq_flags #(.ADDR_W(AW), .MBOX_EN(1'b0)) i_mbox_irq_flags_off (
      .clk(clk), .rst_n(rst_n),
      .lt_en(lt_en), .lt_oe(lt_oe), .lt_wr(lt_wr), .lt_addr(lt_addr), .lt_busy(lt_busy),
      .rt_en(rt_en), .rt_oe(rt_oe), .rt_wr(rt_wr), .rt_addr(rt_addr), .rt_busy(rt_busy),
      .lt_irq(off_lt), .rt_irq(off_rt));

   typedef struct {
      logic  lt;
      logic  rt;
      string tag;
   } exp_t;

   exp_t sb[$];
   int total = 0;
   int bad = 0;
   logic m_lt = 0, m_rt = 0;
   bit finished = 0;

   task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got lt/rt=%b expected %b", tag, got, exp);
      end
   endtask

   // Driver: applies one cycle of stimulus and pushes the model's next state.
   task automatic step(input logic [2:0] lc, input logic [AW-1:0] la, input logic lb,
                       input logic [2:0] rc, input logic [AW-1:0] ra, input logic rb,
                       input string tag);
      logic lset, lclr, rset, rclr;
      exp_t e;
      @(negedge clk);
      {lt_en, lt_oe, lt_wr} = lc; lt_addr = la; lt_busy = lb;
      {rt_en, rt_oe, rt_wr} = rc; rt_addr = ra; rt_busy = rb;
      lset = rc[2] & rc[0] & ~rb & (ra == LTM);
      lclr = lc[2] & lc[1] & ~lb & (la == LTM);
      rset = lc[2] & lc[0] & ~lb & (la == RTM);
      rclr = rc[2] & rc[1] & ~rb & (ra == RTM);
      m_lt = lset ? 1'b1 : (lclr ? 1'b0 : m_lt);
      m_rt = rset ? 1'b1 : (rclr ? 1'b0 : m_rt);
      e.lt = m_lt; e.rt = m_rt; e.tag = tag;
      sb.push_back(e);
   endtask

   // Monitor: compares after each rising edge.
   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(e.tag, {lt_irq, rt_irq}, {e.lt, e.rt});
         check({e.tag, " R9"}, {off_lt, off_rt}, 2'b00);
      end
   end

   localparam logic [2:0] IDLE = 3'b000, WR = 3'b101, RD = 3'b110, RDW = 3'b111;

   initial begin
      repeat (3) @(negedge clk);
      check("R1", {lt_irq, rt_irq}, 2'b00);
      rst_n = 1'b1;
      step(IDLE, 0, 0, IDLE, 0, 0, "R8 idle");
      step(IDLE, 0, 0, WR, LTM, 0, "R2 right posts left");
      step(IDLE, 0, 0, IDLE, 0, 0, "R8 hold");
      step(RDW, LTM, 0, IDLE, 0, 0, "R3 clear with write high");
      step(WR, RTM, 0, IDLE, 0, 0, "R4 left posts right");
      step(IDLE, 0, 0, RD, LTM, 0, "R8 right reads wrong word");
      step(IDLE, 0, 0, 3'b100, RTM, 0, "R8 right no oe");
      step(IDLE, 0, 0, RD, RTM, 1, "R6 right clear busy");
      step(IDLE, 0, 0, RD, RTM, 0, "R5 right clears");
      step(WR, RTM, 1, IDLE, 0, 0, "R6 left post busy");
      step(RD, LTM, 0, WR, LTM, 0, "R7 set beats clear");
      step(RD, LTM, 0, IDLE, 0, 0, "R3 plain read clears");
      step(WR, LTM, 0, WR, 11'h7FD, 0, "R8 own word and near address");
      step(IDLE, 0, 0, WR, LTM, 1, "R6 right post busy");
      step(WR, RTM, 0, WR, LTM, 0, "R2 R4 both post");
      step(3'b010, LTM, 0, IDLE, 0, 0, "R8 left no enable");
      step(3'b100, LTM, 0, 3'b011, RTM, 0, "R8 no oe either side");
      step(RD, LTM, 1, RD, RTM, 1, "R6 both busy");
      step(RD, LTM, 0, RD, RTM, 0, "R3 R5 both clear");
      step(IDLE, 0, 0, IDLE, 0, 0, "R8 final idle");
      repeat (3) @(negedge clk);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #20000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule